// File: doc/BRIEF.md
# DRAM Power-Up Initialization Sequencer

This block sits on the controller side of a graphics DDR SDRAM link. It takes the device from power-on to a usable state. While reset is applied it holds clock-enable low. It then waits out a stable-clock interval that is set from the clock frequency and a time in microseconds. After that it raises clock-enable and plays a fixed list of commands on the command, bank and address pins. Each command is separated from the next by the minimum spacing the device needs.

The list runs in this order:
1. Precharge-all.
2. Extended-register write that turns the DLL on.
3. Mode-register write with the DLL-reset bit set.
4. A second precharge-all.
5. A programmable number of auto-refresh commands.
6. A final mode-register write with the DLL-reset bit clear.

The final write is held back until the DLL has had its full lock interval since the DLL-reset write. Burst length, burst type and output drive strength come from configuration ports. Codes that the device does not accept are replaced with legal ones.

Two cycles after the final write, the block raises a one-cycle `init_done` pulse. From that cycle on, the controller's own command inputs drive the pins. Until that cycle those inputs have no effect.

Top module: `gddr_bringup_seq`

## Requirements
- R1: After reset is released, CKE stays low for exactly CLK_MHZ*STABLE_US clock cycles. The command pins show NOP ({cs,ras,cas,we} = 0111) during that whole time.
- R2: Exactly one NOP cycle with CKE high comes before the first command. The non-NOP commands then appear in this order, with nothing else between them: precharge-all, extended write, mode write with A8=1, precharge-all, NUM_REFRESH auto-refreshes, mode write with A8=0.
- R3: Command codes on {cs,ras,cas,we}: precharge-all is 0010 with A10=1; auto-refresh is 0001 with address 0; a register write is 0000. BA=00 selects the mode register and BA=01 selects the extended register.
- R4: The next command follows exactly T_RP cycles after a precharge and exactly T_MRD cycles after a register write. It follows exactly T_RFC cycles after an auto-refresh, except where R5 delays the final write.
- R5: The final mode write is issued at the later of two times: T_RFC cycles after the last refresh, or LOCK_CYC cycles after the DLL-reset write.
- R6: In a mode write, A2:A0 carry the burst code (001=2, 010=4, 011=8) and A3 the burst type (1=interleave). A6:A4=011 and A7=0. A8 is the DLL-reset flag and all other bits are 0. The reserved burst codes (000 and 1xx) are written as 010.
- R7: In an extended write, A0=0 (DLL on), A1 carries drive bit 0 and A6 carries drive bit 1. All other bits are 0. Drive code 11 is written as 00.
- R8: `init_done` is high for exactly one cycle, T_MRD cycles after the final mode write.
- R9: Before the `init_done` cycle, the user command, bank and address inputs have no effect on the pins. From that cycle on, the pins follow those inputs directly and CKE stays high.
- R10: Asserting reset drops CKE, returns the pins to NOP, clears `init_done` and restarts the whole sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_code | input | 3 | Burst length code for the mode register |
| cfg_interleave | input | 1 | Burst type, 1 = interleave |
| cfg_drive | input | 2 | Output drive strength code |
| usr_cs_n | input | 1 | User chip select, passed through after handover |
| usr_ras_n | input | 1 | User row strobe |
| usr_cas_n | input | 1 | User column strobe |
| usr_we_n | input | 1 | User write enable |
| usr_ba | input | BA_W | User bank address |
| usr_addr | input | ADDR_W | User address |
| dram_cke | output | 1 | Clock enable to the device |
| dram_cs_n | output | 1 | Chip select to the device |
| dram_ras_n | output | 1 | Row strobe to the device |
| dram_cas_n | output | 1 | Column strobe to the device |
| dram_we_n | output | 1 | Write enable to the device |
| dram_ba | output | BA_W | Bank address to the device |
| dram_addr | output | ADDR_W | Address to the device |
| init_done | output | 1 | One-cycle pulse when the device is ready |

## Verification
Two events can fall in the same cycle:
- The handover cycle, in which `init_done` rises and the user inputs first reach the pins.
- Expiry of the lock wait, which can coincide with expiry of the refresh spacing when the final write is released.

The bench drives a read-like user command all through initialization. A leak would therefore show up as an extra command in the scoreboard. In the `init_done` cycle itself, the pins must already carry that user command.

The final write is judged against a spacing the bench computes as the larger of the refresh gap and the remaining lock time. One run is cut off by reset in the middle of the lock wait, to show that the timing starts again from the beginning.

// File: rtl/gddr_init_pkg.sv
package gddr_init_pkg;

    // Command pins packed as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_REGSET  = 4'b0000,
        CMD_REFRESH = 4'b0001,
        CMD_PRECH   = 4'b0010,
        CMD_NOP     = 4'b0111
    } dram_cmd_e;

    // Each phase names the next command the sequencer will issue
    typedef enum logic [3:0] {
        PH_HOLD,
        PH_PREA,
        PH_EXT,
        PH_DLLRST,
        PH_PREB,
        PH_REFR,
        PH_FINAL,
        PH_HAND,
        PH_RUN
    } seq_phase_e;

    localparam int PRECH_ALL_BIT = 10;
    localparam int DLL_RST_BIT   = 8;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gddr_cycle_timer.sv
module gddr_cycle_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/gddr_mode_words.sv
module gddr_mode_words #(
    parameter int ADDR_W = 13
) (
    input  logic [2:0]        cfg_burst_code,
    input  logic              cfg_interleave,
    input  logic [1:0]        cfg_drive,
    output logic [ADDR_W-1:0] mode_rst_word,
    output logic [ADDR_W-1:0] mode_run_word,
    output logic [ADDR_W-1:0] ext_word
);
    import gddr_init_pkg::*;

    logic [2:0]        burst_ok;
    logic [1:0]        drive_ok;
    logic [ADDR_W-1:0] mode_base;

    always_comb begin
        // Only 2, 4 and 8 are legal; anything else becomes 4
        unique case (cfg_burst_code)
            3'b001, 3'b010, 3'b011: burst_ok = cfg_burst_code;
            default:                burst_ok = 3'b010;
        endcase
        drive_ok = (cfg_drive == 2'b11) ? 2'b00 : cfg_drive;

        mode_base      = '0;
        mode_base[2:0] = burst_ok;
        mode_base[3]   = cfg_interleave;
        mode_base[6:4] = 3'b011;        // read latency 3
        mode_base[7]   = 1'b0;          // normal operation, never test

        mode_run_word = mode_base;
        mode_rst_word = mode_base;
        mode_rst_word[DLL_RST_BIT] = 1'b1;

        ext_word    = '0;               // A0 low keeps the DLL on
        ext_word[1] = drive_ok[0];
        ext_word[6] = drive_ok[1];
    end

endmodule

// File: rtl/gddr_cmd_mux.sv
module gddr_cmd_mux #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input  logic              handover,
    input  logic [3:0]        seq_cmd,
    input  logic [BA_W-1:0]   seq_ba,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [3:0]        usr_cmd,
    input  logic [BA_W-1:0]   usr_ba,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic [3:0]        pin_cmd,
    output logic [BA_W-1:0]   pin_ba,
    output logic [ADDR_W-1:0] pin_addr
);
    always_comb begin
        if (handover) begin
            pin_cmd  = usr_cmd;
            pin_ba   = usr_ba;
            pin_addr = usr_addr;
        end else begin
            pin_cmd  = seq_cmd;
            pin_ba   = seq_ba;
            pin_addr = seq_addr;
        end
    end

endmodule

// File: rtl/gddr_bringup_seq.sv
module gddr_bringup_seq
    import gddr_init_pkg::*;
#(
    parameter int CLK_MHZ     = 50,
    parameter int STABLE_US   = 200,
    parameter int T_RP        = 4,
    parameter int T_MRD       = 2,
    parameter int T_RFC       = 14,
    parameter int LOCK_CYC    = 200,
    parameter int NUM_REFRESH = 2,
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_code,
    input  logic              cfg_interleave,
    input  logic [1:0]        cfg_drive,
    input  logic              usr_cs_n,
    input  logic              usr_ras_n,
    input  logic              usr_cas_n,
    input  logic              usr_we_n,
    input  logic [BA_W-1:0]   usr_ba,
    input  logic [ADDR_W-1:0] usr_addr,
    output logic              dram_cke,
    output logic              dram_cs_n,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [BA_W-1:0]   dram_ba,
    output logic [ADDR_W-1:0] dram_addr,
    output logic              init_done
);
    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
    localparam int MAX_GAP    = max_of(max_of(STABLE_CYC, T_RFC), max_of(T_RP, T_MRD));
    localparam int WAIT_W     = $clog2(MAX_GAP + 1);
    localparam int LOCK_W     = $clog2(LOCK_CYC + 1);
    localparam int REF_W      = $clog2(NUM_REFRESH + 1);

    localparam logic [WAIT_W-1:0] GAP_WAKE = '0;
    localparam logic [WAIT_W-1:0] GAP_RP   = WAIT_W'(T_RP - 1);
    localparam logic [WAIT_W-1:0] GAP_MRD  = WAIT_W'(T_MRD - 1);
    localparam logic [WAIT_W-1:0] GAP_RFC  = WAIT_W'(T_RFC - 1);
    localparam logic [LOCK_W-1:0] LOCK_LD  = LOCK_W'(LOCK_CYC - 1);

    typedef struct packed {
        seq_phase_e        phase;
        logic [REF_W-1:0]  refs;
        logic              cke;
        dram_cmd_e         cmd;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic              ready;
    } seq_state_t;

    localparam seq_state_t RESET_ST = '{
        phase: PH_HOLD,
        refs:  '0,
        cke:   1'b0,
        cmd:   CMD_NOP,
        ba:    '0,
        addr:  '0,
        done:  1'b0,
        ready: 1'b0
    };

    seq_state_t st_d, st_q;

    logic              wait_load_d;
    logic [WAIT_W-1:0] wait_val_d;
    logic              wait_zero;
    logic              lock_load_d;
    logic              lock_zero;
    logic [ADDR_W-1:0] mode_rst_word;
    logic [ADDR_W-1:0] mode_run_word;
    logic [ADDR_W-1:0] ext_word;
    logic [3:0]        pin_cmd;
    logic              handover_q;

    // Spacing between commands; its reset value covers the stable-clock wait
    gddr_cycle_timer #(
        .W       (WAIT_W),
        .RST_VAL (STABLE_CYC - 1)
    ) u_gap_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load_d),
        .load_val (wait_val_d),
        .expired  (wait_zero)
    );

    // DLL lock interval, started by the DLL-reset write
    gddr_cycle_timer #(
        .W       (LOCK_W),
        .RST_VAL (0)
    ) u_lock_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lock_load_d),
        .load_val (LOCK_LD),
        .expired  (lock_zero)
    );

    gddr_mode_words #(
        .ADDR_W (ADDR_W)
    ) u_words (
        .cfg_burst_code (cfg_burst_code),
        .cfg_interleave (cfg_interleave),
        .cfg_drive      (cfg_drive),
        .mode_rst_word  (mode_rst_word),
        .mode_run_word  (mode_run_word),
        .ext_word       (ext_word)
    );

    always_comb begin
        st_d        = st_q;
        st_d.cmd    = CMD_NOP;
        st_d.ba     = '0;
        st_d.addr   = '0;
        st_d.done   = 1'b0;
        wait_load_d = 1'b0;
        wait_val_d  = GAP_WAKE;
        lock_load_d = 1'b0;

        unique case (st_q.phase)
            PH_HOLD: begin
                if (wait_zero) begin
                    st_d.cke    = 1'b1;
                    wait_load_d = 1'b1;
                    wait_val_d  = GAP_WAKE;
                    st_d.phase  = PH_PREA;
                end
            end
            PH_PREA, PH_PREB: begin
                if (wait_zero) begin
                    st_d.cmd                 = CMD_PRECH;
                    st_d.addr[PRECH_ALL_BIT] = 1'b1;
                    wait_load_d              = 1'b1;
                    wait_val_d               = GAP_RP;
                    st_d.phase = (st_q.phase == PH_PREA) ? PH_EXT : PH_REFR;
                end
            end
            PH_EXT: begin
                if (wait_zero) begin
                    st_d.cmd    = CMD_REGSET;
                    st_d.ba     = BA_W'(1);
                    st_d.addr   = ext_word;
                    wait_load_d = 1'b1;
                    wait_val_d  = GAP_MRD;
                    st_d.phase  = PH_DLLRST;
                end
            end
            PH_DLLRST: begin
                if (wait_zero) begin
                    st_d.cmd    = CMD_REGSET;
                    st_d.addr   = mode_rst_word;
                    wait_load_d = 1'b1;
                    wait_val_d  = GAP_MRD;
                    lock_load_d = 1'b1;
                    st_d.phase  = PH_PREB;
                end
            end
            PH_REFR: begin
                if (wait_zero) begin
                    st_d.cmd    = CMD_REFRESH;
                    wait_load_d = 1'b1;
                    wait_val_d  = GAP_RFC;
                    st_d.refs   = st_q.refs + 1'b1;
                    if (st_q.refs == REF_W'(NUM_REFRESH - 1)) begin
                        st_d.phase = PH_FINAL;
                    end
                end
            end
            PH_FINAL: begin
                if (wait_zero && lock_zero) begin
                    st_d.cmd    = CMD_REGSET;
                    st_d.addr   = mode_run_word;
                    wait_load_d = 1'b1;
                    wait_val_d  = GAP_MRD;
                    st_d.phase  = PH_HAND;
                end
            end
            PH_HAND: begin
                if (wait_zero) begin
                    st_d.done  = 1'b1;
                    st_d.ready = 1'b1;
                    st_d.phase = PH_RUN;
                end
            end
            default: begin
                st_d.phase = PH_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign handover_q = st_q.ready;

    gddr_cmd_mux #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_mux (
        .handover (handover_q),
        .seq_cmd  (st_q.cmd),
        .seq_ba   (st_q.ba),
        .seq_addr (st_q.addr),
        .usr_cmd  ({usr_cs_n, usr_ras_n, usr_cas_n, usr_we_n}),
        .usr_ba   (usr_ba),
        .usr_addr (usr_addr),
        .pin_cmd  (pin_cmd),
        .pin_ba   (dram_ba),
        .pin_addr (dram_addr)
    );

    assign {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} = pin_cmd;
    assign dram_cke  = st_q.cke;
    assign init_done = st_q.done;

endmodule

// File: rtl/gddr_bringup_chk.sv
module gddr_bringup_chk #(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dram_cke,
    input logic              dram_cs_n,
    input logic              dram_ras_n,
    input logic              dram_cas_n,
    input logic              dram_we_n,
    input logic [BA_W-1:0]   dram_ba,
    input logic [ADDR_W-1:0] dram_addr,
    input logic              init_done,
    input logic              handover_q
);
    logic [3:0] pins;
    logic       is_nop, is_regset, is_prech;

    assign pins      = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
    assign is_nop    = (pins == 4'b0111);
    assign is_regset = (pins == 4'b0000);
    assign is_prech  = (pins == 4'b0010);

    AST_CKE_LOW_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cke |-> is_nop);  // R1

    AST_PRECH_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!handover_q && is_prech) |-> dram_addr[10]);  // R3

    // Holds for T_MRD of two or more
    AST_REGSET_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (!handover_q && is_regset) |=> is_nop);  // R4

    AST_MODE_FIXED_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!handover_q && is_regset && dram_ba == '0) |-> (dram_addr[7:4] == 4'b0011));  // R6

    AST_EXT_LEGAL_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!handover_q && is_regset && dram_ba == BA_W'(1)) |-> (!dram_addr[0] && !(dram_addr[1] && dram_addr[6])));  // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> !init_done);  // R8

    AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> ($past(is_regset, 2) && !$past(dram_addr[8], 2)));  // R8

    AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (handover_q || init_done) |-> dram_cke);  // R9

endmodule

bind gddr_bringup_seq gddr_bringup_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (.*);

// File: tb/gddr_bringup_seq_test.sv
module gddr_bringup_seq_test;

    localparam int CLK_MHZ    = 50;
    localparam int STABLE_US  = 200;
    localparam int T_RP       = 4;
    localparam int T_MRD      = 2;
    localparam int T_RFC      = 14;
    localparam int LOCK_CYC   = 200;
    localparam int NUM_REF    = 2;
    localparam int STABLE_CYC = CLK_MHZ * STABLE_US;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_REG = 4'b0000;

    logic        clk, rst_n;
    logic [2:0]  cfg_burst_code;
    logic        cfg_interleave;
    logic [1:0]  cfg_drive;
    logic [3:0]  usr_cmd;
    logic [1:0]  usr_ba;
    logic [12:0] usr_addr;
    logic        dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n;
    logic [1:0]  dram_ba;
    logic [12:0] dram_addr;
    logic        init_done;

    gddr_bringup_seq #(
        .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP), .T_MRD(T_MRD),
        .T_RFC(T_RFC), .LOCK_CYC(LOCK_CYC), .NUM_REFRESH(NUM_REF),
        .ADDR_W(13), .BA_W(2)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_code(cfg_burst_code), .cfg_interleave(cfg_interleave), .cfg_drive(cfg_drive),
        .usr_cs_n(usr_cmd[3]), .usr_ras_n(usr_cmd[2]), .usr_cas_n(usr_cmd[1]), .usr_we_n(usr_cmd[0]),
        .usr_ba(usr_ba), .usr_addr(usr_addr),
        .dram_cke(dram_cke), .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_ba(dram_ba), .dram_addr(dram_addr), .init_done(init_done)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        int          gap;
        string       tag;
    } exp_t;

    exp_t expq[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [12:0] exp_mode(input logic [2:0] bl, input logic il, input logic dll);
        logic [12:0] a;
        a      = '0;
        a[2:0] = (bl == 3'b001 || bl == 3'b010 || bl == 3'b011) ? bl : 3'b010;
        a[3]   = il;
        a[6:4] = 3'b011;
        a[8]   = dll;
        return a;
    endfunction

    function automatic logic [12:0] exp_ext(input logic [1:0] drv);
        logic [12:0] a;
        logic [1:0]  d;
        d    = (drv == 2'b11) ? 2'b00 : drv;
        a    = '0;
        a[1] = d[0];
        a[6] = d[1];
        return a;
    endfunction

    task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a,
                        input int gap, input string tag);
        exp_t e;
        e.cmd = c; e.ba = b; e.addr = a; e.gap = gap; e.tag = tag;
        expq.push_back(e);
    endtask

    // Driver side of the scoreboard: expected commands and spacings
    task automatic load_plan(input logic [2:0] bl, input logic il, input logic [1:0] drv);
        int t;
        int fin;
        push(C_PRE, 2'b00, 13'h0400, 1, "R2/R3 first precharge");
        push(C_REG, 2'b01, exp_ext(drv), T_RP, "R7 extended write");
        push(C_REG, 2'b00, exp_mode(bl, il, 1'b1), T_MRD, "R6 dll reset write");
        push(C_PRE, 2'b00, 13'h0400, T_MRD, "R4 second precharge");
        t = T_MRD;
        push(C_REF, 2'b00, 13'h0000, T_RP, "R3 refresh");
        t += T_RP;
        for (int k = 1; k < NUM_REF; k++) begin
            push(C_REF, 2'b00, 13'h0000, T_RFC, "R4 refresh spacing");
            t += T_RFC;
        end
        fin = t + T_RFC;
        if (fin < LOCK_CYC) fin = LOCK_CYC;
        push(C_REG, 2'b00, exp_mode(bl, il, 1'b0), fin - t, "R5 final write");
    endtask

    // Monitor side of the scoreboard
    int cyc, low_cnt, last_t, hcnt;
    bit seen, handed, nop_bad;

    always @(negedge clk) begin
        logic [3:0] pc;
        exp_t e;
        pc = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};
        if (!rst_n) begin
            expq.delete();
            cyc = 0; low_cnt = 0; last_t = 0; hcnt = 0;
            seen = 0; handed = 0; nop_bad = 0;
        end else begin
            cyc++;
            if (!handed) begin
                if (!seen) begin
                    if (!dram_cke) begin
                        low_cnt++;
                        if (pc != C_NOP) nop_bad = 1;
                    end else begin
                        seen   = 1;
                        last_t = cyc;
                        check(low_cnt == STABLE_CYC, "R1", "cke low cycles", low_cnt, STABLE_CYC);
                        check(!nop_bad, "R1", "non-NOP while cke low", nop_bad, 0);
                        check(pc == C_NOP, "R2", "wake cycle command", pc, C_NOP);
                    end
                end else if (init_done) begin
                    check(expq.size() == 0, "R2", "commands left before done", expq.size(), 0);
                    check(cyc - last_t == T_MRD, "R8", "done delay", cyc - last_t, T_MRD);
                    check({pc, dram_ba, dram_addr} == {usr_cmd, usr_ba, usr_addr} && dram_cke,
                          "R9", "pins at handover", {pc, dram_ba, dram_addr}, {usr_cmd, usr_ba, usr_addr});
                    handed = 1;
                end else if (pc != C_NOP || !dram_cke) begin
                    if (expq.size() == 0) begin
                        check(0, "R2/R9", "unexpected command", {dram_cke, pc}, {1'b1, C_NOP});
                    end else begin
                        e = expq.pop_front();
                        check({pc, dram_ba, dram_addr} == {e.cmd, e.ba, e.addr}, e.tag, "cmd/ba/addr",
                              {pc, dram_ba, dram_addr}, {e.cmd, e.ba, e.addr});
                        check(cyc - last_t == e.gap, e.tag, "spacing", cyc - last_t, e.gap);
                        last_t = cyc;
                    end
                end
            end else begin
                hcnt++;
                if (hcnt == 1) check(!init_done, "R8", "done width", init_done, 0);
                if (hcnt <= 4)
                    check({pc, dram_ba, dram_addr} == {usr_cmd, usr_ba, usr_addr} && dram_cke,
                          "R9", "pass-through", {dram_cke, pc, dram_ba, dram_addr},
                          {1'b1, usr_cmd, usr_ba, usr_addr});
            end
        end
    end

    task automatic check_reset_state(input string what);
        check(!dram_cke && {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == C_NOP && !init_done,
              "R10", what, {dram_cke, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, init_done},
              {1'b0, C_NOP, 1'b0});
    endtask

    task automatic run(input logic [2:0] bl, input logic il, input logic [1:0] drv, input int abort);
        rst_n          = 1'b0;
        cfg_burst_code = bl;
        cfg_interleave = il;
        cfg_drive      = drv;
        usr_cmd        = 4'b0101;   // read-like command held during init
        usr_ba         = 2'b11;
        usr_addr       = 13'h1abc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        load_plan(bl, il, drv);
        if (abort > 0) begin
            while (!dram_cke) @(negedge clk);
            repeat (abort) @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            check_reset_state("reset during lock wait");
            repeat (2) @(posedge clk);
            #1 rst_n = 1'b1;
            load_plan(bl, il, drv);
        end
        while (!init_done) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            #1;
            usr_cmd  = 4'(k + 2);
            usr_ba   = 2'(k);
            usr_addr = 13'(13'h0155 << k);
        end
        @(negedge clk);
    endtask

    initial begin
        rst_n          = 1'b0;
        cfg_burst_code = 3'b011;
        cfg_interleave = 1'b0;
        cfg_drive      = 2'b00;
        usr_cmd        = 4'b0101;
        usr_ba         = 2'b11;
        usr_addr       = 13'h1abc;
        repeat (3) @(negedge clk);
        check_reset_state("state in reset");
        run(3'b011, 1'b0, 2'b01, 0);     // burst 8, sequential, weak
        run(3'b001, 1'b1, 2'b10, 0);     // burst 2, interleave, matched
        run(3'b101, 1'b0, 2'b11, 100);   // reserved burst and drive, restart mid-lock
        run(3'b000, 1'b1, 2'b00, 0);     // reserved burst, full drive
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule